// File: doc/BRIEF.md
# Eight-Bit Accumulator Arithmetic and Logic Unit

This is a purely combinational data path for a small accumulator machine. Each cycle it takes the accumulator value, a second operand (another register or a byte fetched from memory), the current carry flag and an operation code. It returns an 8-bit result, four condition flags (negative, zero, overflow, carry) and a 16-bit unsigned product. The surrounding processor decodes instructions, fetches operands, writes the result back and latches the flags. This block only computes the values.

Single-operand operations (negate, complement, clear, increment, decrement, shifts, rotates) act on the accumulator operand and ignore the second operand. The flags come out packed as `flags_o = {N, Z, V, C}`, with N in bit 3 and C in bit 0. For each operation, C is either given a new value or passed through from `cin_i`.

Top module: `acc_alu`

## Requirements
- R1: Operation codes on `op_i` are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 complement, 8 negate, 9 clear, 10 increment, 11 decrement, 12 logical shift right, 13 arithmetic shift right, 14 shift left, 15 rotate right, 16 rotate left, 17 multiply. For every code except 17, N (bit 3 of `flags_o`) equals bit 7 of `res_o`, and Z (bit 2) is 1 exactly when `res_o` is zero.
- R2: Add gives A+B and add-with-carry gives A+B+cin, modulo 256. Plain add ignores `cin_i`. C is 1 when the unsigned sum exceeds 255. V is 1 when the signed sum lies outside -128..127.
- R3: Subtract gives A-B and subtract-with-borrow gives A-B-cin, modulo 256. Plain subtract ignores `cin_i`. C is 1 when the unsigned difference is below 0. V is 1 when the signed difference lies outside -128..127.
- R4: AND, OR and XOR combine A with B. Complement gives the bitwise inverse of A. All four force V to 0. AND, OR and XOR pass `cin_i` to C, while complement forces C to 1.
- R5: Clear gives result 0 with flags N=0, Z=1, V=0, C=0.
- R6: Negate gives 0-A modulo 256. C is 1 when the result is nonzero, and V is 1 when A is 0x80.
- R7: Increment gives A+1 and decrement gives A-1, modulo 256. Both pass `cin_i` to C. V is 1 only for increment of 0x7F and decrement of 0x80.
- R8: Logical shift right fills bit 7 with 0. Arithmetic shift right keeps bit 7. Shift left fills bit 0 with 0. In each case the bit shifted out goes to C, and V equals N XOR C.
- R9: Rotate right moves `cin_i` into bit 7 and bit 0 into C. Rotate left moves `cin_i` into bit 0 and bit 7 into C. V equals N XOR C.
- R10: `prod_o` is always the unsigned product A×B, with the high byte in bits 15:8. For code 17, `res_o` is the low byte of the product, N=0, V=0, Z is 1 when the product is zero, and C equals product bit 7.
- R11: Codes 18 to 31 return A unchanged, with V=0 and C equal to `cin_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand A |
| opd_i | input | 8 | Second operand B |
| cin_i | input | 1 | Incoming carry flag |
| res_o | output | 8 | Result byte |
| flags_o | output | 4 | {N, Z, V, C} |
| prod_o | output | 16 | Unsigned product A×B |

## Verification
The block holds no state, so a fault in its internal arithmetic appears at the outputs as soon as the inputs change, within the same evaluation. A wrong borrow or carry polarity shows up in C on the first vector whose unsigned result wraps. A miswired shift or rotate shows up in the bit that enters at the vacated end or in C. The bench drives directed corner vectors (0x7F, 0x80, 0x00, 0xFF, with the carry set and clear) followed by random ones. It compares every output against an integer model once per clock.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W   = 8,
  parameter int OPW = 5
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   opd_i,
  input  logic           cin_i,
  output logic [W-1:0]   res_o,
  output logic [3:0]     flags_o,
  output logic [2*W-1:0] prod_o
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  localparam logic [OPW-1:0] OP_ADD = 0,  OP_ADC = 1,  OP_SUB = 2,  OP_SBC = 3;
  localparam logic [OPW-1:0] OP_AND = 4,  OP_OR  = 5,  OP_XOR = 6,  OP_COM = 7;
  localparam logic [OPW-1:0] OP_NEG = 8,  OP_CLR = 9,  OP_INC = 10, OP_DEC = 11;
  localparam logic [OPW-1:0] OP_LSR = 12, OP_ASR = 13, OP_ASL = 14, OP_ROR = 15;
  localparam logic [OPW-1:0] OP_ROL = 16, OP_MUL = 17;

  logic [W-1:0] r;
  logic         n, z, v, c;
  logic         sh_v;

  assign prod_o = {{W{1'b0}}, acc_i} * {{W{1'b0}}, opd_i};

  always_comb begin
    r    = acc_i;
    c    = cin_i;
    v    = 1'b0;
    sh_v = 1'b0;
    case (op_i)
      OP_ADD: begin
        {c, r} = {1'b0, acc_i} + {1'b0, opd_i};
        v = (acc_i[MSB] == opd_i[MSB]) && (r[MSB] != acc_i[MSB]);
      end
      OP_ADC: begin
        {c, r} = {1'b0, acc_i} + {1'b0, opd_i} + {{W{1'b0}}, cin_i};
        v = (acc_i[MSB] == opd_i[MSB]) && (r[MSB] != acc_i[MSB]);
      end
      OP_SUB: begin
        {c, r} = {1'b0, acc_i} - {1'b0, opd_i};
        v = (acc_i[MSB] != opd_i[MSB]) && (r[MSB] != acc_i[MSB]);
      end
      OP_SBC: begin
        {c, r} = {1'b0, acc_i} - {1'b0, opd_i} - {{W{1'b0}}, cin_i};
        v = (acc_i[MSB] != opd_i[MSB]) && (r[MSB] != acc_i[MSB]);
      end
      OP_AND: r = acc_i & opd_i;
      OP_OR:  r = acc_i | opd_i;
      OP_XOR: r = acc_i ^ opd_i;
      OP_COM: begin
        r = ~acc_i;
        c = 1'b1;
      end
      OP_NEG: begin
        r = {W{1'b0}} - acc_i;
        c = (acc_i != {W{1'b0}});
        v = (acc_i == SMIN);
      end
      OP_CLR: begin
        r = {W{1'b0}};
        c = 1'b0;
      end
      OP_INC: begin
        r = acc_i + {{(W-1){1'b0}}, 1'b1};
        v = (acc_i == SMAX);
      end
      OP_DEC: begin
        r = acc_i - {{(W-1){1'b0}}, 1'b1};
        v = (acc_i == SMIN);
      end
      OP_LSR: begin
        r = {1'b0, acc_i[MSB:1]};
        c = acc_i[0];
        sh_v = 1'b1;
      end
      OP_ASR: begin
        r = {acc_i[MSB], acc_i[MSB:1]};
        c = acc_i[0];
        sh_v = 1'b1;
      end
      OP_ASL: begin
        r = {acc_i[MSB-1:0], 1'b0};
        c = acc_i[MSB];
        sh_v = 1'b1;
      end
      OP_ROR: begin
        r = {cin_i, acc_i[MSB:1]};
        c = acc_i[0];
        sh_v = 1'b1;
      end
      OP_ROL: begin
        r = {acc_i[MSB-1:0], cin_i};
        c = acc_i[MSB];
        sh_v = 1'b1;
      end
      OP_MUL: begin
        r = prod_o[W-1:0];
        c = prod_o[MSB];
      end
      default: ;
    endcase
    n = r[MSB];
    z = (r == {W{1'b0}});
    if (op_i == OP_MUL) begin
      n = 1'b0;
      z = (prod_o == {(2*W){1'b0}});
    end
    if (sh_v) v = n ^ c;
  end

  assign res_o   = r;
  assign flags_o = {n, z, v, c};

  always_comb begin
    // R5
    clr_flags_chk: assert (op_i != OP_CLR || (res_o == '0 && flags_o == 4'b0100));
    // R6
    neg_sum_chk: assert (op_i != OP_NEG || (res_o + acc_i) == '0);
    // R9
    rol_path_chk: assert (op_i != OP_ROL || (res_o[0] == cin_i && flags_o[0] == acc_i[MSB]));
    // R9
    ror_path_chk: assert (op_i != OP_ROR || (res_o[MSB] == cin_i && flags_o[0] == acc_i[0]));
    // R4
    logic_no_ovf_chk: assert (!(op_i inside {OP_AND, OP_OR, OP_XOR, OP_COM}) || !flags_o[1]);
    // R10
    mul_low_chk: assert (op_i != OP_MUL || res_o == prod_o[W-1:0]);
    // R8
    shl_fill_chk: assert (op_i != OP_ASL || (res_o[0] == 1'b0 && flags_o[0] == acc_i[MSB]));
  end
endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic       ci = 1'b0;
  logic [7:0] res;
  logic [3:0] fl;
  logic [15:0] prod;
  int checks = 0, fails = 0;
  bit  done = 0;

  acc_alu uut (.op_i(op), .acc_i(a), .opd_i(b), .cin_i(ci),
               .res_o(res), .flags_o(fl), .prod_o(prod));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_of(input int o);
    case (o)
      0, 1: return "R2";
      2, 3: return "R3";
      4, 5, 6, 7: return "R4";
      8: return "R6";
      9: return "R5";
      10, 11: return "R7";
      12, 13, 14: return "R8";
      15, 16: return "R9";
      17: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic int sgn(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  // model returns {res[7:0], n, z, v, c} packed in an int
  function automatic int model(input int o, input int x, input int y, input int cc);
    int t, s, r, n, z, v, c;
    c = cc; v = 0; t = x;
    case (o)
      0, 1: begin
        t = x + y + ((o == 1) ? cc : 0);
        s = sgn(x) + sgn(y) + ((o == 1) ? cc : 0);
        c = (t > 255); v = (s > 127 || s < -128);
      end
      2, 3: begin
        t = x - y - ((o == 3) ? cc : 0);
        s = sgn(x) - sgn(y) - ((o == 3) ? cc : 0);
        c = (t < 0); v = (s > 127 || s < -128);
      end
      4: t = x & y;
      5: t = x | y;
      6: t = x ^ y;
      7: begin t = 255 - x; c = 1; end
      8: begin t = -x; c = (t < 0); v = (-sgn(x) > 127); end
      9: begin t = 0; c = 0; end
      10: begin t = x + 1; v = (sgn(x) + 1 > 127); end
      11: begin t = x - 1; v = (sgn(x) - 1 < -128); end
      12: begin t = x / 2; c = x % 2; end
      13: begin t = x / 2 + (x >= 128 ? 128 : 0); c = x % 2; end
      14: begin t = x * 2; c = (x >= 128); end
      15: begin t = x / 2 + cc * 128; c = x % 2; end
      16: begin t = x * 2 + cc; c = (x >= 128); end
      17: begin t = x * y; c = ((t / 128) % 2); end
      default: t = x;
    endcase
    r = ((t % 256) + 256) % 256;
    n = (r >= 128); z = (r == 0);
    if (o == 17) begin n = 0; z = (x * y == 0); end
    if (o >= 12 && o <= 16) v = n ^ c;
    return r * 16 + n * 8 + z * 4 + v * 2 + c;
  endfunction

  task automatic apply(input int o, input int x, input int y, input int cc);
    int e;
    @(posedge clk);
    op = o[4:0]; a = x[7:0]; b = y[7:0]; ci = cc[0];
    @(negedge clk);
    e = model(o, x, y, cc);
    checks++;
    if (o != 17 && fl[3:2] != e[3:2]) begin
      fails++;
      $display("FAIL R1 op=%0d a=%02h: NZ=%b expected %b", o, x, fl[3:2], e[3:2]);
    end
    checks++;
    if (res != e[11:4] || fl != e[3:0]) begin
      fails++;
      $display("FAIL %s op=%0d a=%02h b=%02h ci=%0d: res/flags=%02h/%b expected %02h/%b",
               tag_of(o), o, x, y, cc, res, fl, e[11:4], e[3:0]);
    end
    checks++;
    if (prod != 16'(x * y)) begin
      fails++;
      $display("FAIL R10 prod=%04h expected %04h", prod, x * y);
    end
  endtask

  initial begin
    int corners[6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'hA5};
    // reset-free block: the first vector covers the all-zero start state
    apply(0, 0, 0, 0);
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int k = 0; k < 2; k++)
            apply(o, corners[i], corners[j], k);
    for (int n = 0; n < 3000; n++)
      apply(int'($urandom_range(31)), int'($urandom_range(255)),
            int'($urandom_range(255)), int'($urandom_range(1)));
    done = 1;
  end

  initial begin
    for (int t = 0; t < 150000 && !done; t++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule